// File: doc/BRIEF.md
# ADC Conversion Sweep Sequencer

This block sequences a multichannel analog-to-digital converter. Software writes a configuration word and a channel-enable mask. It then sets a start bit, and the block walks the enabled channels from the lowest index to the highest. For each channel it issues a one-cycle start to an abstract converter and waits for that converter's done strobe.

There are two sweep modes. In single-pass mode the block converts every enabled channel once and then idles. At that point it raises a data-available flag, and an active-low data-ready output follows the flag. In repeat mode the sweep wraps from the last enabled channel back to the first and keeps running. The flag is held at zero in this mode. Instead, the data-ready output gives a timed low pulse of one microsecond at the end of every sweep.

The flag can be cleared in three ways: a data-register read strobe, the launch of a new sweep, or a configuration write carrying zero in the flag position. A status-register read strobe leaves the flag untouched.

Top module: `adc_sweep_seq`

## Requirements
- R1: After reset the configuration readback is 0x2000 (repeat mode), the mask readback is 0, data-ready is high and no converter start is issued.
- R2: Configuration bit 13 is the mode (1 = repeat, 0 = single-pass), bit 12 is the start bit and bit 7 is the data-available flag. Every other bit ignores writes and reads back 0.
- R3: A write with bit 12 set makes bit 12 read 1 in the following cycle. In the cycle after that, bit 12 reads 0 and the converter start is high for the lowest enabled channel.
- R4: Enabled channels are converted in ascending index order, one start pulse per channel. The next start is issued in the cycle after the converter's done strobe.
- R5: In single-pass mode, the done of the highest enabled channel sets the flag (bit 7 reads 1) and drives data-ready low. No further start is issued.
- R6: The flag is cleared by a data-read strobe, by a configuration write with bit 7 = 0, or by the launch of a sweep. A status-read strobe does not clear it, and writing 1 to bit 7 does not set it.
- R7: In repeat mode the sweep wraps to the lowest enabled channel after the highest, and the flag reads 0 throughout.
- R8: In repeat mode, each done of the highest enabled channel drives data-ready low for exactly CLK_HZ/1,000,000 cycles.
- R9: Clearing the mode bit during a repeat sweep lets the channel in flight finish. No further start is issued, and the flag stays 0.
- R10: A start request with an all-zero mask is ignored: no converter start, the flag is unchanged, and bit 12 reads 0 again after one cycle.
- R11: A start request during a sweep restarts the sweep at the lowest enabled channel and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration word write strobe |
| cfgWrData | input | 16 | Configuration write data |
| cfgRdData | output | 16 | Configuration word readback |
| maskWr | input | 1 | Channel-enable mask write strobe |
| maskWrData | input | NUM_CH | Channel-enable mask write data |
| maskRdData | output | NUM_CH | Channel-enable mask readback |
| dataRd | input | 1 | Data-register read strobe |
| statusRd | input | 1 | Status-register read strobe |
| convStart | output | 1 | One-cycle start to the converter |
| convChan | output | CH_W | Channel being converted |
| convDone | input | 1 | Converter done strobe |
| davN | output | 1 | Active-low data-ready |

## Verification
The bench builds the block with NUM_CH = 8 and CLK_HZ = 5,000,000. This makes the end-of-sweep pulse five cycles long, which fits inside a three-channel repeat sweep, so both the pulse length and its spacing can be measured. The eight channels let random masks, single-channel masks at either end of the range, and the full mask all be swept. The converter model's three-cycle latency leaves room to clear the mode bit or re-issue a start in the middle of a channel.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef struct packed {
    logic startTaken;
    logic launch;
    logic setFlag;
    logic loadPulse;
  } seqStrobe_t;

  typedef enum logic {ST_IDLE, ST_CONV} seqState_t;
endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PULSE_CYC = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [15:0]       cfgWrData,
  input  logic              maskWr,
  input  logic [NUM_CH-1:0] maskWrData,
  input  logic              dataRd,
  input  logic              statusRd,
  input  seqStrobe_t        strb,
  output logic [15:0]       cfgRdData,
  output logic [NUM_CH-1:0] maskQ,
  output logic              modeQ,
  output logic              startPendQ,
  output logic              davN
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [15:0] MODE_BIT  = 16'h2000;
  localparam logic [15:0] START_BIT = 16'h1000;
  localparam logic [15:0] FLAG_BIT  = 16'h0080;

  logic flagQ, flagNext, modeNext;
  logic wrMode, wrStart, wrFlag;
  logic [CNT_W-1:0] pulseCnt;

  assign wrMode  = |(cfgWrData & MODE_BIT);
  assign wrStart = |(cfgWrData & START_BIT);
  assign wrFlag  = |(cfgWrData & FLAG_BIT);
  assign modeNext = cfgWr ? wrMode : modeQ;

  always_comb begin
    flagNext = flagQ;
    if ((cfgWr && !wrFlag) || dataRd || strb.launch) flagNext = 1'b0;
    if (strb.setFlag) flagNext = 1'b1;
    if (modeNext) flagNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ      <= 1'b1;
      startPendQ <= 1'b0;
      flagQ      <= 1'b0;
      maskQ      <= '0;
      pulseCnt   <= '0;
    end else begin
      if (cfgWr) modeQ <= wrMode;
      if (maskWr) maskQ <= maskWrData;
      if (cfgWr && wrStart) startPendQ <= 1'b1;
      else if (strb.startTaken) startPendQ <= 1'b0;
      flagQ <= flagNext;
      if (strb.loadPulse) pulseCnt <= CNT_W'(PULSE_CYC);
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign davN = !(flagQ || (pulseCnt != '0));
  assign cfgRdData = {2'b00, modeQ, startPendQ, 4'b0000, flagQ, 7'b0000000};

  assert_start_selfclear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startPendQ && !cfgWr) |=> !startPendQ);
  assert_flag_repeat_R7: assert property (@(posedge clk) disable iff (!rstN)
    modeQ |-> !flagQ);
  assert_status_noclear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && statusRd && !cfgWr && !dataRd && !strb.launch) |=> flagQ);
  assert_pulse_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPulse |=> !davN);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] mask,
  input  logic              mode,
  input  logic              startPend,
  input  logic              convDone,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  output seqStrobe_t        strb
);
  seqState_t state, nState;
  logic [CH_W-1:0] chan, nChan, firstCh, aboveIdx;
  logic sweepRep, nRep, nStart, anyCh, aboveFound, lastHit;

  always_comb begin
    firstCh = '0;
    aboveIdx = '0;
    aboveFound = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) firstCh = CH_W'(i);
      if (mask[i] && i > int'(chan)) begin
        aboveIdx = CH_W'(i);
        aboveFound = 1'b1;
      end
    end
  end
  assign anyCh = |mask;
  assign lastHit = !aboveFound;

  always_comb begin
    strb = '0;
    nState = state;
    nChan = chan;
    nStart = 1'b0;
    nRep = sweepRep;
    if (startPend) begin
      strb.startTaken = 1'b1;
      if (anyCh) begin
        strb.launch = 1'b1;
        nState = ST_CONV;
        nChan = firstCh;
        nStart = 1'b1;
        nRep = mode;
      end
    end else if (state == ST_CONV && convDone) begin
      if (sweepRep && lastHit) strb.loadPulse = 1'b1;
      if (sweepRep && !mode) begin
        nState = ST_IDLE;
      end else if (!lastHit) begin
        nChan = aboveIdx;
        nStart = 1'b1;
      end else if (sweepRep) begin
        if (anyCh) begin
          nChan = firstCh;
          nStart = 1'b1;
        end else begin
          nState = ST_IDLE;
        end
      end else begin
        strb.setFlag = 1'b1;
        nState = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      chan <= '0;
      convStart <= 1'b0;
      sweepRep <= 1'b0;
    end else begin
      state <= nState;
      chan <= nChan;
      convStart <= nStart;
      sweepRep <= nRep;
    end
  end

  assign convChan = chan;

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !convStart);
  assert_empty_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (startPend && mask == '0) |=> (!convStart && state == $past(state) && chan == $past(chan)));
  assert_launch_first_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> (convStart && convChan == $past(firstCh)));
  assert_advance_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && convDone && !startPend && aboveFound && !(sweepRep && !mode))
      |=> (convStart && convChan > $past(chan)));
endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CLK_HZ = 50_000_000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PULSE_CYC = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [15:0]       cfgWrData,
  output logic [15:0]       cfgRdData,
  input  logic              maskWr,
  input  logic [NUM_CH-1:0] maskWrData,
  output logic [NUM_CH-1:0] maskRdData,
  input  logic              dataRd,
  input  logic              statusRd,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  input  logic              convDone,
  output logic              davN
);
  seqStrobe_t strb;
  logic [NUM_CH-1:0] maskQ;
  logic modeQ, startPendQ;

  seq_regs #(.NUM_CH(NUM_CH), .PULSE_CYC(PULSE_CYC)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWrData(cfgWrData),
    .maskWr(maskWr), .maskWrData(maskWrData), .dataRd(dataRd),
    .statusRd(statusRd), .strb(strb), .cfgRdData(cfgRdData),
    .maskQ(maskQ), .modeQ(modeQ), .startPendQ(startPendQ), .davN(davN)
  );

  seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mask(maskQ), .mode(modeQ),
    .startPend(startPendQ), .convDone(convDone), .convStart(convStart),
    .convChan(convChan), .strb(strb)
  );

  assign maskRdData = maskQ;
endmodule

// File: tb/sim_adc_sweep_seq.sv
module sim_adc_sweep_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int CLK_HZ = 5_000_000;
  localparam int PULSE = CLK_HZ / 1_000_000;
  localparam int LAT = 3;

  logic clk = 0, rstN = 0, cfgWr = 0, maskWr = 0, dataRd = 0, statusRd = 0, convDone = 0;
  logic [15:0] cfgWrData = 0, cfgRdData;
  logic [NUM_CH-1:0] maskWrData = 0, maskRdData;
  logic convStart, davN;
  logic [2:0] convChan;

  int nTests = 0, nFail = 0, busy = 0, lowRun = 0, lastRun = 0, pulseCount = 0;
  int chanLog[$];
  int seedDummy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_sweep_seq #(.NUM_CH(NUM_CH), .CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .maskWr(maskWr), .maskWrData(maskWrData), .maskRdData(maskRdData),
    .dataRd(dataRd), .statusRd(statusRd), .convStart(convStart),
    .convChan(convChan), .convDone(convDone), .davN(davN)
  );

  // converter model, start log and pulse meter
  always @(negedge clk) begin
    if (convStart) begin
      chanLog.push_back(int'(convChan));
      busy = LAT;
      convDone <= 1'b0;
    end else begin
      convDone <= 1'b0;
      if (busy > 0) begin
        busy = busy - 1;
        if (busy == 0) convDone <= 1'b1;
      end
    end
    if (!davN) lowRun = lowRun + 1;
    else if (lowRun > 0) begin
      lastRun = lowRun;
      pulseCount = pulseCount + 1;
      lowRun = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int firstOf(input logic [NUM_CH-1:0] m);
    for (int i = 0; i < NUM_CH; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic cfgWrite(input logic [15:0] d);
    @(negedge clk); cfgWr = 1; cfgWrData = d;
    @(negedge clk); cfgWr = 0;
  endtask

  task automatic maskWrite(input logic [NUM_CH-1:0] m);
    @(negedge clk); maskWr = 1; maskWrData = m;
    @(negedge clk); maskWr = 0;
  endtask

  task automatic waitDav();
    for (int k = 0; k < 400 && davN; k++) @(negedge clk);
  endtask

  task automatic runSingle(input logic [NUM_CH-1:0] m);
    int exp[$];
    int n;
    for (int i = 0; i < NUM_CH; i++) if (m[i]) exp.push_back(i);
    maskWrite(m);
    chanLog.delete();
    cfgWrite(16'h1000);
    chk("R3 start bit set", int'(cfgRdData[12]), 1);
    chk("R3 no early start", int'(convStart), 0);
    @(negedge clk);
    chk("R3 start bit cleared", int'(cfgRdData[12]), 0);
    chk("R3 launch first chan", convStart ? int'(convChan) : -1, firstOf(m));
    waitDav();
    chk("R5 flag set", int'(cfgRdData[7]), 1);
    chk("R5 davN low", int'(davN), 0);
    n = chanLog.size();
    chk("R4 sweep length", n, exp.size());
    for (int i = 0; i < n && i < exp.size(); i++) chk("R4 ascending order", chanLog[i], exp[i]);
    repeat (10) @(negedge clk);
    chk("R5 no starts after sweep", chanLog.size(), n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int L;
    seedDummy = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 cfg reset", int'(cfgRdData), 16'h2000);
    chk("R1 mask reset", int'(maskRdData), 0);
    chk("R1 davN reset", int'(davN), 1);
    chk("R1 no start", int'(convStart), 0);

    cfgWrite(16'hCF7F);
    chk("R2 reserved read 0", int'(cfgRdData), 16'h0000);
    cfgWrite(16'hEF7F);
    chk("R2 mode bit only", int'(cfgRdData), 16'h2000);
    cfgWrite(16'h2080);
    chk("R6 write 1 no set", int'(cfgRdData), 16'h2000);

    chanLog.delete();
    cfgWrite(16'h1000);
    chk("R10 pending visible", int'(cfgRdData[12]), 1);
    @(negedge clk);
    chk("R10 pending dropped", int'(cfgRdData[12]), 0);
    repeat (10) @(negedge clk);
    chk("R10 no start", chanLog.size(), 0);
    chk("R10 davN high", int'(davN), 1);
    chk("R10 flag unchanged", int'(cfgRdData[7]), 0);

    runSingle(8'h01);
    runSingle(8'h80);
    runSingle(8'hFF);
    for (int r = 0; r < 4; r++) runSingle(NUM_CH'($urandom_range(1, 255)));

    @(negedge clk); statusRd = 1;
    @(negedge clk); statusRd = 0;
    chk("R6 status read keeps flag", int'(cfgRdData[7]), 1);
    chk("R6 status read keeps davN", int'(davN), 0);
    @(negedge clk); dataRd = 1;
    @(negedge clk); dataRd = 0;
    chk("R6 data read clears flag", int'(cfgRdData[7]), 0);
    chk("R6 data read davN high", int'(davN), 1);

    runSingle(8'h5A);
    cfgWrite(16'h0000);
    chk("R6 write 0 clears flag", int'(cfgRdData[7]), 0);
    chk("R6 write 0 davN high", int'(davN), 1);

    runSingle(8'h24);
    cfgWrite(16'h1080);
    chk("R6 write 1 keeps flag", int'(cfgRdData[7]), 1);
    @(negedge clk);
    chk("R6 launch clears flag", int'(cfgRdData[7]), 0);
    waitDav();

    maskWrite(8'hF0);
    chanLog.delete();
    cfgWrite(16'h1000);
    for (int k = 0; k < 100 && chanLog.size() < 2; k++) @(negedge clk);
    #1;
    cfgWrite(16'h1000);
    waitDav();
    chk("R11 restart length", chanLog.size(), 6);
    if (chanLog.size() == 6) begin
      chk("R11 seq0", chanLog[0], 4); chk("R11 seq1", chanLog[1], 5);
      chk("R11 restart at first", chanLog[2], 4); chk("R11 seq3", chanLog[3], 5);
      chk("R11 seq4", chanLog[4], 6); chk("R11 seq5", chanLog[5], 7);
    end
    chk("R11 flag after restart sweep", int'(cfgRdData[7]), 1);

    maskWrite(8'h26);
    chanLog.delete();
    pulseCount = 0;
    cfgWrite(16'h3000);
    chk("R7 launch clears flag", int'(cfgRdData[7]), 0);
    repeat (45) @(negedge clk);
    chk("R7 flag held 0", int'(cfgRdData[7]), 0);
    chk("R7 enough starts", int'(chanLog.size() >= 9), 1);
    for (int i = 0; i < 9 && i < chanLog.size(); i++)
      chk("R7 wrap order", chanLog[i], (i % 3 == 0) ? 1 : (i % 3 == 1) ? 2 : 5);
    chk("R8 pulses seen", int'(pulseCount >= 2), 1);
    chk("R8 pulse width", lastRun, PULSE);

    @(negedge clk);
    while (!convStart) @(negedge clk);
    #1;
    L = chanLog.size();
    cfgWr = 1; cfgWrData = 16'h0000;
    @(negedge clk); cfgWr = 0;
    repeat (30) @(negedge clk);
    chk("R9 no start after stop", chanLog.size(), L);
    chk("R9 davN high", int'(davN), 1);
    chk("R9 flag stays 0", int'(cfgRdData[7]), 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule